// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Set/Clear Control Words

This block controls 32 general-purpose pins from a simple word-wide register bus. The pins form two banks of 16. Bank 0 holds pins 0 to 15, and bank 1 holds pins 16 to 31. Each bank has its own copy of eight 16-bit control registers:

- output value
- output enable
- open-drain enable
- two alternate-function selects
- pull-up enable
- pull-down enable
- input enable

Each bank also has a read-only pin level register.

Every control write uses a split word. A 1 in the lower half turns the matching pin bit on. A 1 in the upper half turns it off. Software can therefore change a single pin without first reading the register.

The block turns the stored controls into registered pad signals for each pin: drive enable, drive level, pull-up and pull-down. It gates the sampled pad level with the input enable when the level register is read.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: A write to a control register changes register bit n to 1 when write bit n is 1, and to 0 when write bit n+16 is 1. A bit whose two write bits are both 0 keeps its value.
- R2: When a write has both the set bit and the clear bit of a pin at 1, the register bit ends at 0.
- R3: Address bit 7 selects the bank: 0 for pins 0 to 15 and 1 for pins 16 to 31. Pin p lives at bit p mod 16 of its bank's registers. An access to one bank never changes the other bank.
- R4: The byte offsets within a bank are:

  | Offset | Register |
  |--------|----------|
  | 0x00 | output value |
  | 0x04 | output enable |
  | 0x08 | open-drain enable |
  | 0x10 | alternate select 1 |
  | 0x14 | alternate select 2 |
  | 0x18 | pull-up enable |
  | 0x1C | pull-down enable |
  | 0x20 | input enable |
  | 0x30 | pin level (read-only) |

- R5: Read data appears on the bus the cycle after the read strobe. For a control register it carries the 16-bit state in bits 15:0 and zeros in bits 31:16. The read data is all zeros in any cycle that does not follow a read strobe.
- R6: A read of offset 0x30 returns each pin's pad level in bits 15:0, forced to 0 for pins whose input enable is 0.
- R7: A pin's pad drive enable is 1 when its output enable is 1 and both of its alternate selects are 0. The pad level output follows the output value. The pad outputs change one cycle after the register write takes effect.
- R8: A pin with open-drain enable at 1 is driven only when its output value is 0. With an output value of 1 its drive enable is 0.
- R9: A read of an unmapped offset, including a misaligned one, returns zero. A write to such an offset changes no register.
- R10: Synchronous reset clears every control register, the read data and all pad outputs to 0.
- R11: The pull-up and pull-down pad outputs of each pin follow that pin's pull-up and pull-down enable registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Set half (15:0) and clear half (31:16) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Sampled pin levels |
| pad_oe | output | 32 | Per-pin drive enable |
| pad_out | output | 32 | Per-pin drive level |
| pad_pu | output | 32 | Per-pin pull-up enable |
| pad_pd | output | 32 | Per-pin pull-down enable |

## Verification
The hardest cases to reach are those where several control registers of one pin interact. The drive enable must fall because of an alternate select or an open-drain high, while the output enable stays at 1. The stimulus first enables three pins and then adds and removes the alternate selects one at a time, so each masking path is seen alone. It then turns on open-drain over a mixed output pattern of high and low pins. A vector table also walks set-only, clear-only and set-plus-clear words across both banks, with misaligned and unmapped writes in between, and reads back each register after every write.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int CTL_COUNT = 8;
  localparam int IDX_OUT  = 0;
  localparam int IDX_OE   = 1;
  localparam int IDX_OD   = 2;
  localparam int IDX_ALT1 = 3;
  localparam int IDX_ALT2 = 4;
  localparam int IDX_PU   = 5;
  localparam int IDX_PD   = 6;
  localparam int IDX_IE   = 7;
  localparam int LEVEL_OFS = 'h30;

  function automatic int ctl_ofs(input int idx);
    case (idx)
      IDX_OUT:  return 'h00;
      IDX_OE:   return 'h04;
      IDX_OD:   return 'h08;
      IDX_ALT1: return 'h10;
      IDX_ALT2: return 'h14;
      IDX_PU:   return 'h18;
      IDX_PD:   return 'h1C;
      IDX_IE:   return 'h20;
      default:  return -1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= (q | set_bits) & ~clr_bits;
  end

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & $past(clr_bits)) == '0));
  p_untouched_hold_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> (((q ^ $past(q)) & ~($past(set_bits) | $past(clr_bits))) == '0));
  p_idle_stable_r1: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
  import gpio_sc_pkg::*;
#(
  parameter int W     = 16,
  parameter int OFS_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic           re,
  input  logic [OFS_W-1:0] ofs,
  input  logic [2*W-1:0] wdata,
  input  logic [W-1:0]   pin_in,
  output logic [2*W-1:0] rdata,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_pu,
  output logic [W-1:0]   pad_pd
);
  localparam int DW = 2 * W;

  logic [W-1:0]  ctl [CTL_COUNT];
  logic [CTL_COUNT-1:0] hit;
  logic          level_hit;
  logic [DW-1:0] rd_mux;
  logic [W-1:0]  drive;

  for (genvar i = 0; i < CTL_COUNT; i++) begin : g_ctl
    assign hit[i] = (int'(ofs) == ctl_ofs(i));
    gpio_sc_reg #(.W(W)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .we       (we && hit[i]),
      .set_bits (wdata[W-1:0]),
      .clr_bits (wdata[DW-1:W]),
      .q        (ctl[i])
    );
  end

  assign level_hit = (int'(ofs) == LEVEL_OFS);

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < CTL_COUNT; i++)
      if (hit[i]) rd_mux = {{W{1'b0}}, ctl[i]};
    if (level_hit) rd_mux = {{W{1'b0}}, pin_in & ctl[IDX_IE]};
  end

  always_comb begin
    drive = ctl[IDX_OE] & ~ctl[IDX_ALT1] & ~ctl[IDX_ALT2]
          & ~(ctl[IDX_OD] & ctl[IDX_OUT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      pad_oe  <= '0;
      pad_out <= '0;
      pad_pu  <= '0;
      pad_pd  <= '0;
    end else begin
      rdata   <= re ? rd_mux : '0;
      pad_oe  <= drive;
      pad_out <= ctl[IDX_OUT];
      pad_pu  <= ctl[IDX_PU];
      pad_pd  <= ctl[IDX_PD];
    end
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (re && (hit == '0) && !level_hit) |=> (rdata == '0));
  p_od_float_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(ctl[IDX_OD] & ctl[IDX_OUT])) == '0));
  p_alt_masks_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(ctl[IDX_ALT1] | ctl[IDX_ALT2])) == '0));
  p_level_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (re && level_hit) |=> ((rdata[W-1:0] & ~$past(ctl[IDX_IE])) == '0));
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl #(
  parameter int PINS_PER_BANK = 16,
  parameter int NUM_BANKS     = 2,
  parameter int ADDR_W        = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic                              bus_wr,
  input  logic [2*PINS_PER_BANK-1:0]        bus_wdata,
  input  logic                              bus_rd,
  output logic [2*PINS_PER_BANK-1:0]        bus_rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_pu,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_pd
);
  localparam int W      = PINS_PER_BANK;
  localparam int DW     = 2 * W;
  localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int OFS_W  = ADDR_W - BSEL_W;

  logic [BSEL_W-1:0] bank_sel;
  logic [OFS_W-1:0]  ofs;
  logic [DW-1:0]     bank_rd [NUM_BANKS];

  assign bank_sel = bus_addr[ADDR_W-1 -: BSEL_W];
  assign ofs      = bus_addr[OFS_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_sel == BSEL_W'(b));
    gpio_sc_bank #(.W(W), .OFS_W(OFS_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we      (bus_wr && sel),
      .re      (bus_rd && sel),
      .ofs     (ofs),
      .wdata   (bus_wdata),
      .pin_in  (pad_in[b*W +: W]),
      .rdata   (bank_rd[b]),
      .pad_oe  (pad_oe[b*W +: W]),
      .pad_out (pad_out[b*W +: W]),
      .pad_pu  (pad_pu[b*W +: W]),
      .pad_pd  (pad_pd[b*W +: W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) bus_rdata |= bank_rd[b];
  end

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:W] == '0);
  p_idle_rdata_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_setclr_ctrl_test.sv
`timescale 1ns/1ps
module gpio_setclr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out, pad_pu, pad_pd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_setclr_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // {write addr, write data, read addr, expected read, requirement}
  localparam int NV = 18;
  localparam logic [87:0] VEC [NV] = '{
    {8'h00, 32'h0000_00A5, 8'h00, 32'h0000_00A5, 8'd1},  // R1 set only
    {8'h00, 32'h0001_0100, 8'h00, 32'h0000_01A4, 8'd1},  // R1 set and clear
    {8'h00, 32'h0004_0004, 8'h00, 32'h0000_01A0, 8'd2},  // R2 both bits
    {8'h80, 32'h0000_F00F, 8'h80, 32'h0000_F00F, 8'd3},  // R3 high bank
    {8'h80, 32'h0000_0000, 8'h00, 32'h0000_01A0, 8'd3},  // R3 isolation
    {8'h04, 32'h0000_FFFF, 8'h04, 32'h0000_FFFF, 8'd4},  // R4
    {8'h08, 32'h0000_1234, 8'h08, 32'h0000_1234, 8'd4},  // R4
    {8'h10, 32'h0000_0001, 8'h10, 32'h0000_0001, 8'd4},  // R4
    {8'h14, 32'h0000_0002, 8'h14, 32'h0000_0002, 8'd4},  // R4
    {8'h18, 32'h0000_8000, 8'h18, 32'h0000_8000, 8'd4},  // R4
    {8'h1C, 32'h0000_4000, 8'h1C, 32'h0000_4000, 8'd4},  // R4
    {8'h20, 32'h0000_FFFF, 8'h20, 32'h0000_FFFF, 8'd4},  // R4
    {8'h9C, 32'hFFFF_FFFF, 8'h9C, 32'h0000_0000, 8'd2},  // R2 full word
    {8'h9C, 32'h0000_FFFF, 8'h9C, 32'h0000_FFFF, 8'd5},  // R5 upper zero
    {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000, 8'd9},  // R9 unmapped
    {8'h02, 32'hFFFF_FFFF, 8'h00, 32'h0000_01A0, 8'd9},  // R9 misaligned
    {8'hA4, 32'h0000_FFFF, 8'hA4, 32'h0000_0000, 8'd9},  // R9 unmapped hi
    {8'h04, 32'hFFFF_0000, 8'h04, 32'h0000_0000, 8'd1}   // R1 clear all
  };

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R10 reset state
    rd(8'h00, d); chk("R10 reset out value", d, 32'h0);
    chk("R10 reset pad_oe", pad_oe, 32'h0);
    chk("R10 reset pad_pu", pad_pu, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][87:80], VEC[i][79:48]);
      rd(VEC[i][47:40], d);
      checks++;
      if (d !== VEC[i][39:8]) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%08h expected=%08h",
                 VEC[i][7:0], i, d, VEC[i][39:8]);
      end
    end

    // R5 idle read data zero between reads
    @(negedge clk); chk("R5 idle rdata", bus_rdata, 32'h0);

    // R7 drive enable with alternate selects
    do_reset();
    wr(8'h00, 32'h0000_0005);
    wr(8'h04, 32'h0000_0007);
    settle();
    chk("R7 pad_oe", pad_oe, 32'h0000_0007);
    chk("R7 pad_out", pad_out, 32'h0000_0005);
    wr(8'h10, 32'h0000_0001); settle();
    chk("R7 alt1 mask", pad_oe, 32'h0000_0006);
    wr(8'h14, 32'h0000_0002); settle();
    chk("R7 alt2 mask", pad_oe, 32'h0000_0004);
    wr(8'h10, 32'h0001_0000);
    wr(8'h14, 32'h0002_0000); settle();
    chk("R7 alt cleared", pad_oe, 32'h0000_0007);

    // R8 open drain: pins 0,2 high float, pin 1 low driven
    wr(8'h08, 32'h0000_0007); settle();
    chk("R8 open drain", pad_oe, 32'h0000_0002);
    chk("R8 level kept", pad_out, 32'h0000_0005);

    // R3 high bank pin 16
    wr(8'h80, 32'h0000_0001);
    wr(8'h84, 32'h0000_0001); settle();
    chk("R3 high bank oe", pad_oe, 32'h0001_0002);
    chk("R3 high bank out", pad_out, 32'h0001_0005);

    // R11 pulls
    wr(8'h98, 32'h0000_0002);
    wr(8'h1C, 32'h0000_0008); settle();
    chk("R11 pull-up", pad_pu, 32'h0002_0000);
    chk("R11 pull-down", pad_pd, 32'h0000_0008);

    // R6 level read gated by input enable
    pad_in = 32'hABCD_1234;
    rd(8'h30, d); chk("R6 level disabled", d, 32'h0);
    wr(8'h20, 32'h0000_00FF);
    rd(8'h30, d); chk("R6 level low bank", d, 32'h0000_0034);
    wr(8'hA0, 32'h0000_FFFF);
    rd(8'hB0, d); chk("R6 level high bank", d, 32'h0000_ABCD);

    // R10 reset after activity
    do_reset();
    rd(8'h04, d); chk("R10 reset oe reg", d, 32'h0);
    chk("R10 reset pad_oe again", pad_oe, 32'h0);
    chk("R10 reset pad_pd", pad_pd, 32'h0);

    finish_run();
  end
endmodule